// File: doc/BRIEF.md
# Mirrored Barrel Shifter

This block is the shift unit of a simple RISC datapath. It takes a 32-bit operand, a 5-bit distance and a 2-bit mode. It returns the operand shifted left logically, right logically or right arithmetically. It has no clock and no state: the result follows the inputs combinationally.

Only one shift network is built, and it moves bits toward the high end. For the two right modes, the operand is mirrored end-for-end on entry, so that bit i swaps with bit 31-i. The mirrored word passes through the left network, and the network's output is mirrored again. Vacated positions are filled with a bit fed in at the low end of the network. That fill bit is zero for the logical modes and the operand's top bit for the arithmetic mode.

The network is a cascade of five stages. Each stage moves the word by a fixed power-of-two distance (1, 2, 4, 8, 16). Each stage is switched on by one bit of the distance.

Top module: `barrel_shift_unit`

## Requirements
- R1: With mode code 2'b00, the result is the operand moved toward the high end by the distance, with zeros entering at bit 0.
- R2: With mode code 2'b01, the result is the operand moved toward the low end by the distance, with zeros entering at bit 31.
- R3: With mode code 2'b10, the result is the operand moved toward the low end by the distance, with copies of operand bit 31 entering at the top.
- R4: Mode code 2'b11 gives the same result as mode code 2'b00 for every operand and distance.
- R5: A distance of zero returns the operand unchanged in every mode.
- R6: At the largest distance (31), a left shift leaves only operand bit 0, now at bit 31. A logical right shift leaves only operand bit 31, now at bit 0. An arithmetic right shift gives a word made entirely of copies of operand bit 31.
- R7: For an operand whose bit 31 is zero, mode 2'b10 gives the same result as mode 2'b01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | Operand to be shifted |
| shamt | input | 5 | Shift distance, 0 to 31 |
| fsel | input | 2 | Mode: 00 left, 01 right logical, 10 right arithmetic, 11 left |
| res | output | 32 | Shifted result |

## Verification
The bench goes after the corners that a mirrored design most easily gets wrong.

- **Sign fill in the wrong place.** If the arithmetic fill were taken from the mirrored bit, or were injected at the wrong end of the network, negative operands would lose their sign or gain ones at the low end. Negative operands under mode 10 at every distance expose this.
- **Missing second mirror.** If the output mirror were left out, right shifts would come back bit-reversed. A zero distance would then fail to return the operand, so every mode is run at distance zero.
- **Mode 11 and distance 31.** If mode 11 fell through to a right shift, or a fill bit leaked into logical modes, the result would differ from a plain left shift. Distance 31 at the extreme, and mode 11 on random data, would show a stray fill bit or a stage wired at the wrong distance.

// File: rtl/shf_pkg.sv
// Package: shared mode encoding for the mirrored barrel shifter.
// Assumes a 2-bit mode field; code 2'b11 is treated as a left shift.
package shf_pkg;
    typedef enum logic [1:0] {
        SHF_LEFT  = 2'b00,
        SHF_RLOG  = 2'b01,
        SHF_RARI  = 2'b10,
        SHF_LEFT2 = 2'b11
    } shf_mode_e;
endpackage

// File: rtl/shf_mirror.sv
// Module: shf_mirror
// Reverses a word end-for-end (bit i goes to bit WIDTH-1-i).
// Assumes nothing beyond WIDTH >= 1; pure wiring.
module shf_mirror #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    // one wire swap per bit position
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign dout[i] = din[WIDTH-1-i];
    end
endmodule

// File: rtl/shf_stage.sv
// Module: shf_stage
// One fixed-distance stage of the left-shifting network: when en is
// high the word moves DIST places toward the high end and the freed
// low positions take the fill bit. Assumes 0 < DIST < WIDTH.
module shf_stage #(
    parameter int WIDTH = 32,
    parameter int DIST  = 1
) (
    input  logic [WIDTH-1:0] din,
    input  logic             fill,
    input  logic             en,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] moved;

    // form the moved word with the fill bit at the low end
    assign moved = {din[WIDTH-1-DIST:0], {DIST{fill}}};

    // pass or move depending on the stage enable
    assign dout = en ? moved : din;
endmodule

// File: rtl/shf_core.sv
// Module: shf_core
// Left-only logarithmic shift network built from AMT_W cascaded
// stages of distance 1, 2, 4, ... Each stage is enabled by one bit
// of the distance. Assumes WIDTH is a power of two.
module shf_core #(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [AMT_W-1:0] amt,
    input  logic             fill,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] lvl [AMT_W+1];

    // entry of the cascade
    assign lvl[0] = din;

    // one stage per distance bit, smallest distance first
    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int D = 1 << s;
        shf_stage #(.WIDTH(WIDTH), .DIST(D)) u_stage (
            .din  (lvl[s]),
            .fill (fill),
            .en   (amt[s]),
            .dout (lvl[s+1])
        );
    end

    // exit of the cascade
    assign dout = lvl[AMT_W];
endmodule

// File: rtl/shf_decode.sv
// Module: shf_decode
// Turns the mode code into the steering controls: whether the
// mirrors are in the path, and which fill bit the core receives.
// Assumes the codes of shf_pkg.
module shf_decode #(
    parameter int WIDTH = 32
) (
    input  logic [1:0]       fsel,
    input  logic             sign_bit,
    output logic             go_right,
    output logic             fill
);
    import shf_pkg::*;

    // decode mode into mirror select and fill source
    always_comb begin
        go_right = 1'b0;
        fill     = 1'b0;
        case (shf_mode_e'(fsel))
            SHF_RLOG: go_right = 1'b1;
            SHF_RARI: begin
                go_right = 1'b1;
                fill     = sign_bit;
            end
            default: begin
                go_right = 1'b0;
                fill     = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/barrel_shift_unit.sv
// Module: barrel_shift_unit
// Combinational 32-bit shift unit. Right shifts reuse the single left
// network by mirroring the operand before it and the result after it.
// Assumes WIDTH is a power of two; the distance is AMT_W bits wide.
module barrel_shift_unit #(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [AMT_W-1:0] shamt,
    input  logic [1:0]       fsel,
    output logic [WIDTH-1:0] res
);
    logic             go_right;
    logic             fill;
    logic [WIDTH-1:0] opa_rev;
    logic [WIDTH-1:0] core_in;
    logic [WIDTH-1:0] core_out;
    logic [WIDTH-1:0] out_rev;

    shf_decode #(.WIDTH(WIDTH)) u_dec (
        .fsel     (fsel),
        .sign_bit (opa[WIDTH-1]),
        .go_right (go_right),
        .fill     (fill)
    );

    shf_mirror #(.WIDTH(WIDTH)) u_mir_in (
        .din  (opa),
        .dout (opa_rev)
    );

    // choose plain or mirrored operand for the core
    assign core_in = go_right ? opa_rev : opa;

    shf_core #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_core (
        .din  (core_in),
        .amt  (shamt),
        .fill (fill),
        .dout (core_out)
    );

    shf_mirror #(.WIDTH(WIDTH)) u_mir_out (
        .din  (core_out),
        .dout (out_rev)
    );

    // restore bit order for right shifts
    assign res = go_right ? out_rev : core_out;
endmodule

// File: rtl/bsu_checker.sv
// Module: bsu_checker
// Property checks on the shift unit's ports. The block has no clock,
// so the checks are immediate and are skipped while any input is unknown.
module bsu_checker #(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input logic [WIDTH-1:0] opa,
    input logic [AMT_W-1:0] shamt,
    input logic [1:0]       fsel,
    input logic [WIDTH-1:0] res
);
    logic known;
    assign known = !$isunknown({opa, shamt, fsel, res});

    // port relations checked whenever the inputs settle
    always_comb begin
        if (known) begin
            AST_ZERO_IDENT: assert (shamt != '0 || res == opa); // R5
            AST_LEFT_LOWZERO: assert (!(fsel == 2'b00 && shamt != '0) || res[0] == 1'b0); // R1
            AST_RLOG_TOPZERO: assert (!(fsel == 2'b01 && shamt != '0) || res[WIDTH-1] == 1'b0); // R2
            AST_RARI_SIGN: assert (fsel != 2'b10 || res[WIDTH-1] == opa[WIDTH-1]); // R3
            AST_ALT_LEFT: assert (!(fsel == 2'b11 && shamt != '0) || res[0] == 1'b0); // R4
            AST_ALT_ONES: assert (fsel != 2'b11 || $countones(res) <= $countones(opa)); // R4
            AST_RARI_POS: assert (!(fsel == 2'b10 && !opa[WIDTH-1]) || $countones(res) <= $countones(opa)); // R7
        end
    end
endmodule

bind barrel_shift_unit bsu_checker #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_chk (
    .opa   (opa),
    .shamt (shamt),
    .fsel  (fsel),
    .res   (res)
);

// File: tb/barrel_shift_unit_test.sv
// Bench: drives one vector after each rising edge and compares the result
// against a behavioural model on the following falling edge.
module barrel_shift_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opa = '0;
    logic [4:0]  shamt = '0;
    logic [1:0]  fsel = '0;
    logic [31:0] res;

    int total = 0;
    int bad = 0;
    logic [31:0] exp_q[$];
    logic [31:0] lfsr = 32'h1ACE_B00C;

    barrel_shift_unit uut (
        .opa   (opa),
        .shamt (shamt),
        .fsel  (fsel),
        .res   (res)
    );

    // free-running clock
    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference for one vector
    function automatic logic [31:0] model(input logic [31:0] a, input int s, input logic [1:0] m);
        case (m)
            2'b01:   return a >> s;
            2'b10:   return $unsigned($signed(a) >>> s);
            default: return a << s;
        endcase
    endfunction

    // requirement tag for a vector
    function automatic string tag(input logic [31:0] a, input int s, input logic [1:0] m);
        if (s == 0) return "R5";
        if (s == 31) return "R6";
        case (m)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return a[31] ? "R3" : "R7";
            default: return "R4";
        endcase
    endfunction

    // drive one vector and check it half a cycle later
    task automatic run(input logic [31:0] a, input int s, input logic [1:0] m);
        logic [31:0] e;
        @(posedge clk);
        #1;
        opa   = a;
        shamt = s[4:0];
        fsel  = m;
        exp_q.push_back(model(a, s, m));
        @(negedge clk);
        e = exp_q.pop_front();
        total++;
        if (res !== e) begin
            bad++;
            $display("FAIL %s opa=%h sh=%0d mode=%0d actual=%h expected=%h",
                     tag(a, s, m), a, s, m, res, e);
        end
        if (m == 2'b11) begin
            total++;
            if (res !== model(a, s, 2'b00)) begin
                bad++;
                $display("FAIL R4 mode3 actual=%h expected=%h", res, model(a, s, 2'b00));
            end
        end
        if (m == 2'b10 && !a[31]) begin
            total++;
            if (res !== model(a, s, 2'b01)) begin
                bad++;
                $display("FAIL R7 actual=%h expected=%h", res, model(a, s, 2'b01));
            end
        end
    endtask

    // watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // stimulus
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if (res !== 32'h0) begin
            bad++;
            $display("FAIL R5 reset-state actual=%h expected=%h", res, 32'h0);
        end
        rst_n = 1'b1;

        // R5: zero distance in every mode
        for (int m = 0; m < 4; m++) begin
            run(32'hDEAD_BEEF, 0, m[1:0]);
            run(32'h0123_4567, 0, m[1:0]);
        end
        // R6: extreme distance
        run(32'hFFFF_FFFE, 31, 2'b00);
        run(32'h0000_0001, 31, 2'b00);
        run(32'h8000_0000, 31, 2'b01);
        run(32'h8000_0000, 31, 2'b10);
        run(32'h7FFF_FFFF, 31, 2'b10);
        // every distance, every mode, with sign set and clear
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 32; s++) begin
                run(32'h8000_0001, s, m[1:0]);
                run(32'hF0F0_A5A5, s, m[1:0]);
                run(32'h4000_0002, s, m[1:0]);
            end
        end
        // pseudo-random sweep
        for (int k = 0; k < 2000; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            run(lfsr ^ (lfsr << 7), int'(lfsr[12:8]), lfsr[3:2]);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule